// File: doc/BRIEF.md
# Peripheral Clock Root Tree

This block is a cycle-level model of the clock root that feeds a chip's peripheral fabric. Every clock is an enable tick on one fast clock. Each source (main PLL, two fractional taps, an alternate source and the crystal oscillator) arrives as a tick input whose rate stands for its frequency. A four-way pre-selector picks the base source, with an internal halver providing the fourth choice. A periph selector, which a PLL-bypass input can force, chooses between that result and the alternate source. The result then passes through three chained dividers:

- the bus divider;
- the register-bus divider, which takes its input from the bus ticks;
- the peripheral-clock divider, which has its own selector between the register-bus ticks and the oscillator.

Software writes configuration words through a simple write port. A change to the periph selector or to the bus divider does not take effect at once. It starts a handshake that sets a busy bit in a status word. The new value is held off for a fixed number of cycles and then applied exactly on a bus tick, so that no bus period is cut short. A further write to a field whose handshake is still running is held in a one-deep queue and started as soon as the running handshake completes. The other fields take effect on the next cycle and do not touch the status word.

Top module: `pclk_root_tree`

## Requirements
- R1: The pre-select field (address 2, bits [1:0]) picks the base tick source: 00 main PLL, 01 fractional tap 2, 10 fractional tap 0, 11 fractional tap 2 divided by 2. The reset value is 01.
- R2: The periph source is the alternate tick input when the periph select bit (address 0, bit 0) or the `pll_bypass` input is 1. When both are 0 it is the pre-select output.
- R3: The bus divider field (address 1, bits [2:0]) divides the periph ticks by field value plus 1, giving ratios 1 to 8. The reset value is 3.
- R4: The register-bus divider field (address 2, bits [9:8]) divides the bus ticks by field value plus 1, giving ratios 1 to 4. The reset value is 2. Every register-bus tick coincides with a bus tick.
- R5: The peripheral-clock select bit (address 2, bit 4) takes the register-bus ticks when 0 and the oscillator ticks when 1. Its divider (address 2, bits [14:12]) divides by field value plus 1. The reset values are select 0 and ratio 1.
- R6: A write to address 0 sets status bit 0 on the next cycle, and a write to address 1 sets status bit 1 on the next cycle. A write to address 2 leaves the status word at 0.
- R7: Status bits read 1 while a handshake is pending and 0 once it is complete, and they are 0 after reset. A busy bit stays set for more than `HS_HOLD` cycles. The new value is applied on a cycle with a bus tick, and the busy bit clears on the next cycle.
- R8: While the bus divider ratio changes, every interval between bus ticks equals either the full old period or the full new period.
- R9: A write to a field whose handshake is pending is queued. It is started when the current handshake completes, so the busy bit stays set across both. Of several queued writes, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pll2 | input | 1 | Main PLL tick |
| src_pfd2 | input | 1 | Fractional tap 2 tick |
| src_pfd0 | input | 1 | Fractional tap 0 tick |
| src_alt | input | 1 | Alternate periph source tick |
| src_osc | input | 1 | Oscillator tick |
| pll_bypass | input | 1 | Forces the periph mux to the alternate source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | DATA_W | Configuration write data |
| hs_busy | output | 2 | Handshake pending: bit 0 periph select, bit 1 bus divider |
| bus_tick | output | 1 | Bus clock enable |
| regbus_tick | output | 1 | Register-bus clock enable |
| perclk_tick | output | 1 | Peripheral clock enable |

## Verification
The sources tick with periods 1, 2, 3, 5 and 7 cycles, so every tick interval measured on an output tells apart which source, pre-select code and divider chain produced it. Directed cases walk all four pre-select codes and both ways of reaching the alternate source. They also cover a divider change under fast ticks, which bounds the busy window, and a change under slow ticks, which must show no partial period. A burst of three back-to-back writes separates the queued value from a lost or overwritten one. Seeded random combinations of all divider and select fields then check the product of ratios on each of the three outputs.

// File: rtl/pclk_root_pkg.sv
package pclk_root_pkg;

  // Configuration word addresses
  localparam int ADDR_PERIPH = 0;
  localparam int ADDR_BUSDIV = 1;
  localparam int ADDR_ROUTE  = 2;

  // Field widths
  localparam int PRE_W  = 2;
  localparam int DIV8_W = 3;
  localparam int DIV4_W = 2;

  typedef enum logic [PRE_W-1:0] {
    PRE_PLL2      = 2'b00,
    PRE_PFD2      = 2'b01,
    PRE_PFD0      = 2'b10,
    PRE_PFD2_HALF = 2'b11
  } pre_sel_e;

  // A divider emits its tick once the count has reached the field value
  // (ratio = field + 1).
  function automatic logic pulse_due(input logic [7:0] cnt, input logic [7:0] field);
    return cnt >= field;
  endfunction

endpackage

// File: rtl/pclk_tick_div.sv
module pclk_tick_div #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_tick,
  input  logic [W-1:0] ratio_m1,
  output logic         out_tick
);
  import pclk_root_pkg::*;

  logic [W-1:0] cnt;

  assign out_tick = in_tick && pulse_due(8'(cnt), 8'(ratio_m1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (in_tick) begin
      cnt <= out_tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pclk_hs_field.sv
module pclk_hs_field #(
  parameter int             W       = 1,
  parameter int             HOLD    = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         boundary,
  output logic [W-1:0] cur,
  output logic         busy,
  output logic         applied
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  target;
  logic [W-1:0]  queued;
  logic          q_valid;

  // Commit when the hold time is over and a tick boundary is present.
  assign applied = busy && (cnt == '0) && boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= RST_VAL;
      target  <= RST_VAL;
      queued  <= RST_VAL;
      q_valid <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else begin
      if (busy && cnt != '0) cnt <= cnt - 1'b1;
      if (applied) begin
        cur <= target;
        if (wr) begin
          target  <= wdata;
          cnt     <= CW'(HOLD);
          q_valid <= 1'b0;
        end else if (q_valid) begin
          target  <= queued;
          cnt     <= CW'(HOLD);
          q_valid <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end else if (wr) begin
        if (busy) begin
          queued  <= wdata;
          q_valid <= 1'b1;
        end else begin
          target <= wdata;
          busy   <= 1'b1;
          cnt    <= CW'(HOLD);
        end
      end
    end
  end
endmodule

// File: rtl/pclk_root_tree.sv
module pclk_root_tree #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16,
  parameter int HS_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_pll2,
  input  logic              src_pfd2,
  input  logic              src_pfd0,
  input  logic              src_alt,
  input  logic              src_osc,
  input  logic              pll_bypass,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [1:0]        hs_busy,
  output logic              bus_tick,
  output logic              regbus_tick,
  output logic              perclk_tick
);
  import pclk_root_pkg::*;

  // Immediate routing fields
  pre_sel_e          pre_sel_q;
  logic              per_sel_q;
  logic [DIV4_W-1:0] regdiv_q;
  logic [DIV8_W-1:0] perdiv_q;

  // Handshaked fields
  logic              periph_sel_cur;
  logic [DIV8_W-1:0] busdiv_cur;
  logic              hs_apply_periph;
  logic              hs_apply_bus;

  // Internal tick nets
  logic pfd2_phase;
  logic pfd2_half;
  logic pre_tick;
  logic periph_tick;
  logic per_src_tick;

  logic wr_periph, wr_busdiv, wr_route;
  logic unused_wbits;

  assign wr_periph    = cfg_we && (cfg_addr == ADDR_W'(ADDR_PERIPH));
  assign wr_busdiv    = cfg_we && (cfg_addr == ADDR_W'(ADDR_BUSDIV));
  assign wr_route     = cfg_we && (cfg_addr == ADDR_W'(ADDR_ROUTE));
  assign unused_wbits = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sel_q <= PRE_PFD2;
      per_sel_q <= 1'b0;
      regdiv_q  <= DIV4_W'(1);
      perdiv_q  <= '0;
    end else if (wr_route) begin
      pre_sel_q <= pre_sel_e'(cfg_wdata[1:0]);
      per_sel_q <= cfg_wdata[4];
      regdiv_q  <= cfg_wdata[9:8];
      perdiv_q  <= cfg_wdata[14:12];
    end
  end

  // Halver on fractional tap 2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pfd2_phase <= 1'b0;
    else if (src_pfd2) pfd2_phase <= ~pfd2_phase;
  end
  assign pfd2_half = src_pfd2 && pfd2_phase;

  always_comb begin
    unique case (pre_sel_q)
      PRE_PLL2:      pre_tick = src_pll2;
      PRE_PFD2:      pre_tick = src_pfd2;
      PRE_PFD0:      pre_tick = src_pfd0;
      PRE_PFD2_HALF: pre_tick = pfd2_half;
      default:       pre_tick = 1'b0;
    endcase
  end

  assign periph_tick = (periph_sel_cur | pll_bypass) ? src_alt : pre_tick;

  pclk_hs_field #(.W(1), .HOLD(HS_HOLD), .RST_VAL(1'b0)) hs_periph_i (
    .clk(clk), .rst_n(rst_n), .wr(wr_periph), .wdata(cfg_wdata[0]),
    .boundary(bus_tick), .cur(periph_sel_cur), .busy(hs_busy[0]),
    .applied(hs_apply_periph)
  );

  pclk_hs_field #(.W(DIV8_W), .HOLD(HS_HOLD), .RST_VAL(DIV8_W'(2))) hs_bus_i (
    .clk(clk), .rst_n(rst_n), .wr(wr_busdiv), .wdata(cfg_wdata[DIV8_W-1:0]),
    .boundary(bus_tick), .cur(busdiv_cur), .busy(hs_busy[1]),
    .applied(hs_apply_bus)
  );

  pclk_tick_div #(.W(DIV8_W)) bus_div_i (
    .clk(clk), .rst_n(rst_n), .in_tick(periph_tick),
    .ratio_m1(busdiv_cur), .out_tick(bus_tick)
  );

  pclk_tick_div #(.W(DIV4_W)) reg_div_i (
    .clk(clk), .rst_n(rst_n), .in_tick(bus_tick),
    .ratio_m1(regdiv_q), .out_tick(regbus_tick)
  );

  assign per_src_tick = per_sel_q ? src_osc : regbus_tick;

  pclk_tick_div #(.W(DIV8_W)) per_div_i (
    .clk(clk), .rst_n(rst_n), .in_tick(per_src_tick),
    .ratio_m1(perdiv_q), .out_tick(perclk_tick)
  );
endmodule

// File: rtl/pclk_root_tree_chk.sv
module pclk_root_tree_chk #(
  parameter int ADDR_W  = 2,
  parameter int HS_HOLD = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [1:0]        hs_busy,
  input logic              bus_tick,
  input logic              regbus_tick,
  input logic              perclk_tick,
  input logic              per_sel_q,
  input logic              hs_apply_bus,
  input logic              hs_apply_periph
);
  import pclk_root_pkg::*;

  logic [15:0] age_bus, age_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_bus <= '0;
      age_per <= '0;
    end else begin
      if (!hs_busy[1])              age_bus <= '0;
      else if (age_bus != 16'hFFFF) age_bus <= age_bus + 1'b1;
      if (!hs_busy[0])              age_per <= '0;
      else if (age_per != 16'hFFFF) age_per <= age_per + 1'b1;
    end
  end

  p_reg_from_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    regbus_tick |-> bus_tick);

  p_per_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (perclk_tick && !per_sel_q) |-> regbus_tick);

  p_bus_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(ADDR_BUSDIV)) |=> hs_busy[1]);

  p_periph_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(ADDR_PERIPH)) |=> hs_busy[0]);

  p_route_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(ADDR_ROUTE) && hs_busy == 2'b00) |=> hs_busy == 2'b00);

  p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_busy[1]) |-> (age_bus > 16'(HS_HOLD)));

  p_periph_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_busy[0]) |-> (age_per > 16'(HS_HOLD)));

  p_bus_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_busy[1]) |-> $past(bus_tick));

  p_apply_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_apply_bus || hs_apply_periph) |-> bus_tick);
endmodule

bind pclk_root_tree pclk_root_tree_chk #(.ADDR_W(ADDR_W), .HS_HOLD(HS_HOLD)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .hs_busy(hs_busy), .bus_tick(bus_tick), .regbus_tick(regbus_tick),
  .perclk_tick(perclk_tick), .per_sel_q(per_sel_q),
  .hs_apply_bus(hs_apply_bus), .hs_apply_periph(hs_apply_periph)
);

// File: tb/pclk_root_tree_tb_top.sv
`timescale 1ns/1ps
module pclk_root_tree_tb_top;
  localparam int HS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_pll2 = 1'b0, src_pfd2 = 1'b0, src_pfd0 = 1'b0;
  logic        src_alt = 1'b0, src_osc = 1'b0, pll_bypass = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  hs_busy;
  logic        bus_tick, regbus_tick, perclk_tick;

  int nchk = 0, nfail = 0, cyc = 0;

  pclk_root_tree #(.ADDR_W(2), .DATA_W(16), .HS_HOLD(HS)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_pll2(src_pll2), .src_pfd2(src_pfd2),
    .src_pfd0(src_pfd0), .src_alt(src_alt), .src_osc(src_osc),
    .pll_bypass(pll_bypass), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hs_busy(hs_busy), .bus_tick(bus_tick),
    .regbus_tick(regbus_tick), .perclk_tick(perclk_tick)
  );

  initial forever #2.5 clk = ~clk;

  // Source ticks with periods 1,2,3,5,7
  initial forever begin
    @(negedge clk);
    cyc++;
    src_pll2 = 1'b1;
    src_pfd2 = (cyc % 2 == 0);
    src_pfd0 = (cyc % 3 == 0);
    src_alt  = (cyc % 5 == 0);
    src_osc  = (cyc % 7 == 0);
  end

  function automatic int src_period(input int pre);
    case (pre)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [15:0] route_word(input int pre, input int psel,
                                             input int rdiv, input int pdiv);
    logic [15:0] d = '0;
    d[1:0]   = 2'(pre);
    d[4]     = 1'(psel);
    d[9:8]   = 2'(rdiv);
    d[14:12] = 3'(pdiv);
    return d;
  endfunction

  function automatic logic tick_of(input int w);
    case (w)
      0: return bus_tick;
      1: return regbus_tick;
      default: return perclk_tick;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (hs_busy != 2'b00 && t < 5000) begin
      @(negedge clk); t++;
    end
  endtask

  // Interval between the 3rd and 4th tick seen on output w
  task automatic meas(input int w, output int per);
    int n = 0, last = 0, t = 0;
    per = -1;
    while (n < 4 && t < 20000) begin
      @(negedge clk); t++;
      if (tick_of(w)) begin
        n++;
        if (n == 4) per = t - last;
        last = t;
      end
    end
  endtask

  task automatic busy_len(input int bit_i, output int len);
    int t = 0;
    len = 0;
    while (hs_busy[bit_i] && t < 5000) begin
      len++; @(negedge clk); t++;
    end
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int p, len, bad;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R7 status, R1/R3 bus 2*3, R4 reg x2, R5 per x1
    check("R7 reset status", int'(hs_busy), 0);
    meas(0, p); check("R1 R3 reset bus period", p, 6);
    meas(1, p); check("R4 reset regbus period", p, 12);
    meas(2, p); check("R5 reset perclk period", p, 12);

    // R1: every pre-select code, R6: route write stays quiet
    for (int pre = 0; pre < 4; pre++) begin
      wr(2, route_word(pre, 0, 1, 0));
      if (pre == 0) check("R6 route write no busy", int'(hs_busy), 0);
      meas(0, p); check("R1 pre-select bus period", p, src_period(pre) * 3);
    end

    // R2: periph select and bypass
    wr(0, 16'h0001);
    check("R6 periph write sets bit0", int'(hs_busy), 1);
    wait_idle();
    meas(0, p); check("R2 periph select alt", p, 15);
    wr(0, 16'h0000); wait_idle();
    @(negedge clk); pll_bypass = 1'b1;
    meas(0, p); check("R2 bypass forces alt", p, 15);
    @(negedge clk); pll_bypass = 1'b0;
    meas(0, p); check("R2 back to pre-select", p, src_period(3) * 3);

    // R7: busy window with fast ticks
    wr(2, route_word(0, 0, 1, 0));
    wr(1, 16'h0004);
    check("R6 busdiv write sets bit1", int'(hs_busy), 2);
    busy_len(1, len);
    check("R7 busy held long enough", int'(len >= HS + 1 && len <= HS + 4), 1);
    meas(0, p); check("R3 bus ratio 5", p, 5);

    // R8: no shortened period during a ratio change
    wr(2, route_word(1, 0, 1, 0));
    wr(1, 16'h0001); wait_idle();
    meas(0, p); check("R3 bus ratio 2", p, 4);
    begin
      int n = 0, last = -1, t = 0;
      bad = 0;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 16'h0004;
      while ((hs_busy != 2'b00 || cfg_we || n < 4) && t < 5000) begin
        @(negedge clk); t++;
        cfg_we = 1'b0;
        if (hs_busy == 2'b00) n++;
        if (bus_tick) begin
          if (last >= 0 && (t - last) != 4 && (t - last) != 10) bad++;
          last = t;
        end
      end
    end
    check("R8 intervals old or new only", bad, 0);
    meas(0, p); check("R8 new bus period", p, 10);

    // R9: queued writes, last wins
    wr(2, route_word(0, 0, 1, 0));
    wr(1, 16'h0002);
    wr(1, 16'h0005);
    wr(1, 16'h0006);
    check("R9 busy during queue", int'(hs_busy[1]), 1);
    busy_len(1, len);
    check("R9 busy spans two handshakes", int'(len >= HS + 1), 1);
    meas(0, p); check("R9 last queued ratio", p, 7);

    // R5: oscillator route
    wr(2, route_word(0, 1, 1, 2));
    meas(2, p); check("R5 perclk from osc", p, 21);
    wr(2, route_word(0, 0, 1, 3));
    meas(2, p); check("R5 perclk from regbus", p, 7 * 2 * 4);

    // Random combinations
    for (int k = 0; k < 8; k++) begin
      int pre = int'($urandom_range(3, 0));
      int b   = int'($urandom_range(7, 0));
      int r   = int'($urandom_range(3, 0));
      int ps  = int'($urandom_range(1, 0));
      int pd  = int'($urandom_range(7, 0));
      int bp, rp;
      wr(2, route_word(pre, ps, r, pd));
      wr(1, 16'(b));
      wait_idle();
      bp = src_period(pre) * (b + 1);
      rp = bp * (r + 1);
      meas(0, p); check("R3 random bus period", p, bp);
      meas(1, p); check("R4 random regbus period", p, rp);
      meas(2, p); check("R5 random perclk period", p, (ps != 0 ? 7 : rp) * (pd + 1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule